// File: doc/BRIEF.md
# Dual-Clock Real-Time Clock Register Bridge

This block is the bus-side register file of a real-time clock whose timekeeping core runs on a slow RTC clock that is unrelated to the bus clock. The core holds a prescaler reload value, a down-counting divider, a seconds-style counter and an alarm compare value. All of these live in the backup domain and survive a bus-side reset. The bus never reads the core directly. It reads shadow copies that are refreshed once per RTC clock period, after the RTC clock edge has been brought into the bus domain. A flag reports that at least one refresh has happened since the bus side came out of reset.

Writes to the reload, counter and alarm values are staged on the bus side while a configuration bit is set. They are handed to the RTC domain only when software clears that bit. A toggle request and a toggle acknowledge carry the hand-off. While it is in flight an idle status bit reads 0 and the block refuses every write. An alarm flag is raised when a refreshed counter value equals the refreshed alarm value. It stays set until software clears it.

The bus port is a single-cycle read/write port. Writes are sampled on the bus clock edge and read data is combinational from the address.

Top module: `rtc_bridge`

## Requirements
- R1: The reload, divider, counter and alarm values are cleared only by `bkp_rstn`. Asserting `presetn` leaves them intact, and the counter keeps advancing while `presetn` is low. Asserting `bkp_rstn` does not touch the bus-side control bits.
- R2: `presetn` clears the bus side. After reset the control word at address 0 reads 0x4 and every shadowed register reads 0 until the first refresh. The control word has configuration at bit 0, refresh-done at bit 1, idle at bit 2 and alarm at bit 3. `alarm_flag` is 0.
- R3: Hardware sets the refresh-done bit (bit 1) on the first shadow refresh after reset. Writing 0 to that bit clears it, and the next refresh sets it again.
- R4: Writes to reload (address 1), counter (address 2) and alarm (address 3) are ignored unless the configuration bit is set.
- R5: While the idle bit reads 0, every bus write is ignored, including writes to the control word.
- R6: A write that clears a set configuration bit starts the transfer. From the next cycle the idle bit reads 0. It stays 0 for at least two full RTC periods and returns to 1 within five RTC periods plus eight bus cycles. Staged values are not visible before the transfer.
- R7: Once the transfer completes and a refresh has followed, reads return the written reload and alarm values. The counter reads the written value plus the few increments since it was applied.
- R8: The counter advances by exactly one every reload+1 RTC cycles. The divider (address 4, read-only) never reads above the reload value.
- R9: `alarm_flag` and control bit 3 are set on a refresh where counter equals alarm. They stay set after the values differ. Writing 0 to bit 3 clears them, and writing 1 to bit 3 never sets them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus clock |
| presetn | input | 1 | Asynchronous active-low bus-side (system) reset |
| rtcclk | input | 1 | Slow RTC clock, at most one quarter of the bus clock rate |
| bkp_rstn | input | 1 | Asynchronous active-low backup-domain reset |
| psel | input | 1 | Access select |
| pwrite | input | 1 | 1 for write, 0 for read |
| paddr | input | 3 | Register word address |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, combinational from paddr |
| alarm_flag | output | 1 | Sticky alarm match flag |

## Verification
Read data is valid in the same cycle as the address, and a write is visible to a read in the next bus cycle. A shadow refresh lands three bus edges after an RTC rising edge. A commit spans three RTC edges plus two or three bus cycles. The bench drives at the falling bus edge and samples one nanosecond later. It polls asynchronous results such as the idle bit, the refresh flag and the alarm in bounded windows, and checks each wait against the limits stated in R6. The counter rate is checked by two reads spaced an exact whole number of RTC periods apart, so the phase of the refresh does not matter and the difference must equal the expected count.

// File: rtl/rtc_bridge_pkg.sv
package rtc_bridge_pkg;

  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL   = 3'd0,
    A_RELOAD = 3'd1,
    A_COUNT  = 3'd2,
    A_ALARM  = 3'd3,
    A_DIV    = 3'd4
  } reg_addr_e;

  // control word bit positions
  localparam int B_CFG  = 0;
  localparam int B_SYNC = 1;
  localparam int B_IDLE = 2;
  localparam int B_ALM  = 3;

  typedef struct packed {
    logic reload;
    logic count;
    logic alarm;
  } wr_mask_t;

endpackage

// File: rtl/rtc_sync.sv
module rtc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= STAGES'({chain, d});
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/rtc_core.sv
module rtc_core
  import rtc_bridge_pkg::*;
#(
  parameter int PRE_W       = 20,
  parameter int CNT_W       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic             rtcclk,
  input  logic             bkp_rstn,
  input  logic             req_tgl,
  input  wr_mask_t         pend,
  input  logic [PRE_W-1:0] stg_reload,
  input  logic [CNT_W-1:0] stg_cnt,
  input  logic [CNT_W-1:0] stg_alarm,
  output logic             ack_tgl,
  output logic [PRE_W-1:0] div_q,
  output logic [PRE_W-1:0] reload_q,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] alarm_q
);

  function automatic logic term_count(input logic [PRE_W-1:0] d);
    return d == '0;
  endfunction

  function automatic logic [PRE_W-1:0] div_next(input logic [PRE_W-1:0] d,
                                                input logic [PRE_W-1:0] rl);
    return term_count(d) ? rl : d - 1'b1;
  endfunction

  logic             req_s;
  logic             apply;
  logic             tc;
  logic             restart;
  logic [PRE_W-1:0] new_reload;

  rtc_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
    .clk(rtcclk), .rst_n(bkp_rstn), .d(req_tgl), .q(req_s)
  );

  assign apply      = req_s ^ ack_tgl;
  assign tc         = term_count(div_q);
  assign restart    = apply && (pend.reload || pend.count);
  assign new_reload = pend.reload ? stg_reload : reload_q;

  always_ff @(posedge rtcclk or negedge bkp_rstn) begin
    if (!bkp_rstn) begin
      ack_tgl  <= 1'b0;
      div_q    <= '0;
      reload_q <= '0;
      cnt_q    <= '0;
      alarm_q  <= '0;
    end else begin
      if (restart) begin
        div_q <= new_reload;
        if (pend.count) cnt_q <= stg_cnt;
      end else begin
        div_q <= div_next(div_q, reload_q);
        if (tc) cnt_q <= cnt_q + 1'b1;
      end
      if (apply) begin
        ack_tgl <= req_s;
        if (pend.reload) reload_q <= stg_reload;
        if (pend.alarm)  alarm_q  <= stg_alarm;
      end
    end
  end

  AST_CNT_STEP: assert property (@(posedge rtcclk) disable iff (!bkp_rstn)
    !apply |=> (cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + 1'b1)); // R8
  AST_DIV_BOUND: assert property (@(posedge rtcclk) disable iff (!bkp_rstn)
    div_q <= reload_q); // R8

endmodule

// File: rtl/rtc_bus_regs.sv
module rtc_bus_regs
  import rtc_bridge_pkg::*;
#(
  parameter int PRE_W       = 20,
  parameter int CNT_W       = 32,
  parameter int DW          = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              pclk,
  input  logic              presetn,
  input  logic              rtcclk,
  input  logic              psel,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DW-1:0]     pwdata,
  output logic [DW-1:0]     prdata,
  input  logic [PRE_W-1:0]  div_in,
  input  logic [PRE_W-1:0]  reload_in,
  input  logic [CNT_W-1:0]  cnt_in,
  input  logic [CNT_W-1:0]  alarm_in,
  input  logic              ack_tgl,
  output logic              req_tgl,
  output wr_mask_t          pend,
  output logic [PRE_W-1:0]  stg_reload,
  output logic [CNT_W-1:0]  stg_cnt,
  output logic [CNT_W-1:0]  stg_alarm,
  output logic              alarm_flag
);

  logic             rclk_s, rclk_d, upd;
  logic             ack_s;
  logic             wr_idle, idle_d, idle_rise;
  logic             wr_ok, stg_ok, ctrl_wr, commit;
  logic             cfg_q, sync_q, alm_q;
  logic [PRE_W-1:0] sh_div, sh_reload;
  logic [CNT_W-1:0] sh_cnt, sh_alarm;

  rtc_sync #(.STAGES(SYNC_STAGES)) u_clk_sync (
    .clk(pclk), .rst_n(presetn), .d(rtcclk), .q(rclk_s)
  );
  rtc_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
    .clk(pclk), .rst_n(presetn), .d(ack_tgl), .q(ack_s)
  );

  // named internal events
  assign upd       = rclk_s & ~rclk_d;
  assign wr_idle   = (req_tgl == ack_s);
  assign idle_rise = wr_idle & ~idle_d;
  assign wr_ok     = psel & pwrite & wr_idle;
  assign stg_ok    = wr_ok & cfg_q;
  assign ctrl_wr   = wr_ok && (paddr == A_CTRL);
  assign commit    = ctrl_wr && cfg_q && !pwdata[B_CFG];

  always_ff @(posedge pclk or negedge presetn) begin
    if (!presetn) begin
      rclk_d     <= 1'b0;
      idle_d     <= 1'b1;
      cfg_q      <= 1'b0;
      sync_q     <= 1'b0;
      alm_q      <= 1'b0;
      req_tgl    <= 1'b0;
      pend       <= '0;
      stg_reload <= '0;
      stg_cnt    <= '0;
      stg_alarm  <= '0;
      sh_div     <= '0;
      sh_reload  <= '0;
      sh_cnt     <= '0;
      sh_alarm   <= '0;
    end else begin
      rclk_d <= rclk_s;
      idle_d <= wr_idle;
      if (upd) begin
        sh_div    <= div_in;
        sh_reload <= reload_in;
        sh_cnt    <= cnt_in;
        sh_alarm  <= alarm_in;
        sync_q    <= 1'b1;
        if (cnt_in == alarm_in) alm_q <= 1'b1;
      end
      if (idle_rise) pend <= '0;
      if (ctrl_wr) begin
        cfg_q <= pwdata[B_CFG];
        if (!pwdata[B_SYNC]) sync_q <= 1'b0;
        if (!pwdata[B_ALM])  alm_q  <= 1'b0;
      end
      if (commit) req_tgl <= ~req_tgl;
      if (stg_ok) begin
        case (paddr)
          A_RELOAD: begin stg_reload <= pwdata[PRE_W-1:0]; pend.reload <= 1'b1; end
          A_COUNT:  begin stg_cnt    <= pwdata[CNT_W-1:0]; pend.count  <= 1'b1; end
          A_ALARM:  begin stg_alarm  <= pwdata[CNT_W-1:0]; pend.alarm  <= 1'b1; end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    prdata = '0;
    case (paddr)
      A_CTRL: begin
        prdata[B_CFG]  = cfg_q;
        prdata[B_SYNC] = sync_q;
        prdata[B_IDLE] = wr_idle;
        prdata[B_ALM]  = alm_q;
      end
      A_RELOAD: prdata = DW'(sh_reload);
      A_COUNT:  prdata = DW'(sh_cnt);
      A_ALARM:  prdata = DW'(sh_alarm);
      A_DIV:    prdata = DW'(sh_div);
      default:  prdata = '0;
    endcase
  end

  assign alarm_flag = alm_q;

  AST_STAGE_LOCK: assert property (@(posedge pclk) disable iff (!presetn)
    (psel && pwrite && (paddr != A_CTRL) && !(cfg_q && wr_idle))
      |=> $stable({stg_reload, stg_cnt, stg_alarm})); // R4
  AST_BUSY_LOCK: assert property (@(posedge pclk) disable iff (!presetn)
    !wr_idle |=> $stable(cfg_q)); // R5
  AST_PEND_HOLD: assert property (@(posedge pclk) disable iff (!presetn)
    !wr_idle |=> $stable(pend)); // R6
  AST_COMMIT_BUSY: assert property (@(posedge pclk) disable iff (!presetn)
    $fell(cfg_q) |-> !wr_idle); // R6
  AST_SYNC_SRC: assert property (@(posedge pclk) disable iff (!presetn)
    $rose(sync_q) |-> $past(upd)); // R3
  AST_ALARM_SRC: assert property (@(posedge pclk) disable iff (!presetn)
    $rose(alm_q) |-> $past(upd)); // R9

endmodule

// File: rtl/rtc_bridge.sv
module rtc_bridge
  import rtc_bridge_pkg::*;
#(
  parameter int PRE_W       = 20,
  parameter int CNT_W       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic        pclk,
  input  logic        presetn,
  input  logic        rtcclk,
  input  logic        bkp_rstn,
  input  logic        psel,
  input  logic        pwrite,
  input  logic [2:0]  paddr,
  input  logic [31:0] pwdata,
  output logic [31:0] prdata,
  output logic        alarm_flag
);
  localparam int DW = 32;

  logic             req_tgl, ack_tgl;
  wr_mask_t         pend;
  logic [PRE_W-1:0] stg_reload, div_q, reload_q;
  logic [CNT_W-1:0] stg_cnt, stg_alarm, cnt_q, alarm_q;

  rtc_bus_regs #(
    .PRE_W(PRE_W), .CNT_W(CNT_W), .DW(DW), .SYNC_STAGES(SYNC_STAGES)
  ) u_bus (
    .pclk(pclk), .presetn(presetn), .rtcclk(rtcclk),
    .psel(psel), .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .div_in(div_q), .reload_in(reload_q), .cnt_in(cnt_q), .alarm_in(alarm_q),
    .ack_tgl(ack_tgl), .req_tgl(req_tgl), .pend(pend),
    .stg_reload(stg_reload), .stg_cnt(stg_cnt), .stg_alarm(stg_alarm),
    .alarm_flag(alarm_flag)
  );

  rtc_core #(
    .PRE_W(PRE_W), .CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)
  ) u_core (
    .rtcclk(rtcclk), .bkp_rstn(bkp_rstn),
    .req_tgl(req_tgl), .pend(pend),
    .stg_reload(stg_reload), .stg_cnt(stg_cnt), .stg_alarm(stg_alarm),
    .ack_tgl(ack_tgl), .div_q(div_q), .reload_q(reload_q),
    .cnt_q(cnt_q), .alarm_q(alarm_q)
  );
endmodule

// File: tb/test_rtc_bridge.sv
module test_rtc_bridge;
  localparam int RTC_PCLK = 10;   // RTC period in bus cycles
  localparam logic [2:0] CTRL = 3'd0, RELOAD = 3'd1, COUNT = 3'd2, ALARM = 3'd3, DIVR = 3'd4;

  logic pclk = 1'b0, rtcclk = 1'b0;
  logic presetn = 1'b0, bkp_rstn = 1'b0;
  logic psel = 1'b0, pwrite = 1'b0;
  logic [2:0] paddr = '0;
  logic [31:0] pwdata = '0, prdata;
  logic alarm_flag;
  int tests = 0, fails = 0, cyc = 0;

  always #2 pclk = ~pclk;
  always #20 rtcclk = ~rtcclk;
  always @(posedge pclk) cyc++;

  rtc_bridge i_rtc_bridge (
    .pclk(pclk), .presetn(presetn), .rtcclk(rtcclk), .bkp_rstn(bkp_rstn),
    .psel(psel), .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata),
    .prdata(prdata), .alarm_flag(alarm_flag)
  );

  function automatic logic [31:0] ctrl_word(bit cfg, bit sync, bit idle, bit alm);
    return {28'd0, alm, idle, sync, cfg};
  endfunction

  function automatic int unsigned ticks_in(int unsigned bus_cycles, int unsigned reload);
    return bus_cycles / (RTC_PCLK * (reload + 1));
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d;
    @(negedge pclk);
    psel = 1'b0; pwrite = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    paddr = a; psel = 1'b1; pwrite = 1'b0;
    #1 d = prdata;
    @(negedge pclk);
    psel = 1'b0;
  endtask

  task automatic wait_idle(output int n);
    logic [31:0] v;
    n = 0;
    for (int i = 0; i < 200; i++) begin
      rd(CTRL, v);
      if (v[2]) break;
      n++;
    end
  endtask

  task automatic wait_sync(output bit seen);
    logic [31:0] v;
    seen = 0;
    for (int i = 0; i < 40; i++) begin
      rd(CTRL, v);
      if (v[1]) begin seen = 1; break; end
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge pclk);
    fails++;
    $display("FAIL watchdog: actual 0x%08h expected 0x%08h", cyc, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin : main
    logic [31:0] v, c1, c2, rl, cv, av;
    int n;
    bit seen;
    v = $urandom(32'd1234);
    repeat (5) @(negedge pclk);
    presetn = 1'b1; bkp_rstn = 1'b1;

    // R2 reset state
    rd(CTRL, v);  check(v == ctrl_word(0, 0, 1, 0), "R2 ctrl after reset", v, ctrl_word(0, 0, 1, 0));
    rd(COUNT, v); check(v == 0, "R2 count before refresh", v, 0);
    check(alarm_flag == 1'b0, "R2 alarm_flag", {31'd0, alarm_flag}, 0);

    // R3 first refresh
    wait_sync(seen);
    check(seen, "R3 refresh flag set", {31'd0, seen}, 1);

    // R4 writes ignored outside configuration
    wr(COUNT, 32'hABCD_0000);
    wr(ALARM, 32'h1234_5678);
    repeat (30) @(negedge pclk);
    rd(COUNT, v); check(v < 32'h1000, "R4 count write ignored", v, 32'h0);
    rd(ALARM, v); check(v == 0, "R4 alarm write ignored", v, 0);
    rd(CTRL, v);  check(v[2] == 1'b1, "R4 no transfer started", v, ctrl_word(0, 1, 1, 0));

    // R5..R8 randomized commits
    for (int it = 0; it < 4; it++) begin
      rl = $urandom % 8;
      cv = $urandom | 32'h0001_0000;
      av = cv ^ 32'h8000_0000;
      wait_idle(n);
      wr(CTRL, 32'h3);
      wr(RELOAD, rl);
      wr(COUNT, cv);
      wr(ALARM, av);
      if (it == 0) begin
        rd(CTRL, v);  check(v[0] && v[2], "R6 cfg set and idle", v, ctrl_word(1, 1, 1, 0));
        rd(COUNT, v); check(v < 32'h1000, "R6 staged count hidden", v, 32'h0);
      end
      wr(CTRL, 32'h2);
      if (it == 0) begin
        rd(CTRL, v); check(v[2] == 1'b0, "R6 idle low after exit", v, ctrl_word(0, 1, 0, 0));
        wr(CTRL, 32'h3);  // attempt while busy
      end
      wait_idle(n);
      check(n >= 2 * RTC_PCLK - 2 && n <= 5 * RTC_PCLK + 8, "R6 busy window", n, 3 * RTC_PCLK);
      if (it == 0) begin
        rd(CTRL, v); check(v[0] == 1'b0, "R5 write during busy ignored", v, ctrl_word(0, 1, 1, 0));
      end
      repeat (25) @(negedge pclk);
      rd(RELOAD, v); check(v == rl, "R7 reload readback", v, rl);
      rd(ALARM, v);  check(v == av, "R7 alarm readback", v, av);
      rd(COUNT, v);  check((v - cv) <= 5, "R7 count readback", v, cv);
      rd(DIVR, v);   check(v <= rl, "R8 divider bound", v, rl);
      rd(COUNT, c1);
      repeat (3 * (rl + 1) * RTC_PCLK - 1) @(negedge pclk);
      rd(COUNT, c2);
      check((c2 - c1) == ticks_in(3 * (rl + 1) * RTC_PCLK, rl), "R8 count rate", c2 - c1, 3);
    end

    // R9 alarm
    cv = $urandom | 32'h0001_0000;
    wait_idle(n);
    wr(CTRL, 32'h3); wr(RELOAD, 32'd1); wr(COUNT, cv); wr(ALARM, cv + 3);
    wr(CTRL, 32'h2);
    wait_idle(n);
    check(alarm_flag == 1'b0, "R9 no alarm before match", {31'd0, alarm_flag}, 0);
    seen = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge pclk);
      if (alarm_flag) begin seen = 1; break; end
    end
    check(seen, "R9 alarm raised on match", {31'd0, seen}, 1);
    repeat (60) @(negedge pclk);
    rd(CTRL, v); check(v[3] == 1'b1, "R9 alarm sticky", v, ctrl_word(0, 1, 1, 1));
    wr(CTRL, 32'h2);
    rd(CTRL, v); check(v[3] == 1'b0 && !alarm_flag, "R9 alarm cleared", v, ctrl_word(0, 1, 1, 0));
    wr(CTRL, 32'hA);
    rd(CTRL, v); check(v[3] == 1'b0, "R9 write 1 does not set", v, ctrl_word(0, 1, 1, 0));
    repeat (40) @(negedge pclk);
    check(alarm_flag == 1'b0, "R9 stays clear", {31'd0, alarm_flag}, 0);

    // R3 software clear and re-set
    wr(CTRL, 32'h0);
    rd(CTRL, v); check(v[1] == 1'b0, "R3 refresh flag cleared", v, ctrl_word(0, 0, 1, 0));
    wait_sync(seen);
    check(seen, "R3 refresh flag set again", {31'd0, seen}, 1);

    // R1/R2 system reset leaves RTC domain running
    rd(COUNT, c1);
    n = cyc;
    presetn = 1'b0;
    repeat (200) @(negedge pclk);
    presetn = 1'b1;
    rd(CTRL, v);  check(v == ctrl_word(0, 0, 1, 0), "R2 ctrl after system reset", v, ctrl_word(0, 0, 1, 0));
    rd(COUNT, v); check(v == 0, "R2 shadow zero after system reset", v, 0);
    wait_sync(seen);
    rd(COUNT, c2);
    v = ticks_in(cyc - n, 1);
    check((c2 - c1) + 1 >= v && (c2 - c1) <= v + 1, "R1 count ran during system reset", c2 - c1, v);
    rd(RELOAD, v); check(v == 1, "R1 reload kept over system reset", v, 1);

    // R1 backup reset clears RTC values but not bus control
    wait_idle(n);
    wr(CTRL, 32'h3);
    bkp_rstn = 1'b0;
    repeat (5) @(negedge pclk);
    bkp_rstn = 1'b1;
    repeat (60) @(negedge pclk);
    rd(CTRL, v);   check(v[0] == 1'b1, "R1 cfg kept over backup reset", v, ctrl_word(1, 1, 1, 0));
    rd(RELOAD, v); check(v == 0, "R1 reload cleared by backup reset", v, 0);
    rd(ALARM, v);  check(v == 0, "R1 alarm cleared by backup reset", v, 0);
    rd(COUNT, v);  check(v <= 8, "R1 count cleared by backup reset", v, 0);
    wr(CTRL, 32'h2);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule